// File: doc/BRIEF.md
# Exception Control Register Block

This block is the system-control register file and exception sequencer beside a 32-bit RISC core. It holds four registers: a status word with an exception-level flag, a cause word, an exception return address and a faulting-address register. The core reports a synchronous exception as a request together with a 5-bit exception code, the PC of the instruction involved and the offending data or fetch address. Devices drive eight level interrupt lines.

In the same cycle as an accepted event, the block raises a redirect strobe with the fixed handler vector. At the next clock edge it records the event. A return-from-exception request redirects the core to the stored return address and clears the exception-level flag. Software reaches the registers by register number through a combinational move-from read port and a clocked move-to write port.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 read as zero, and `redirect` is low while no request is present.
- R2: An exception request with a supported code (4 fetch/load address fault, 5 store address fault, 8 syscall, 9 break, 10 unknown opcode, 12 add/sub overflow, 13 trap) raises `redirect` in the same cycle with `redirect_pc` = 0x80000180. After the next edge, Status (register 12) bit 1 is 1, Cause (register 13) bits 6:2 hold the code and EPC (register 14) holds `ev_pc`.
- R3: BadVAddr (register 8) takes `ev_addr` only on a taken exception with code 4 or 5. No other event changes it.
- R4: An exception request with any other code is ignored: no redirect and no register change. Divide-by-zero has no code, so it never reaches the handler.
- R5: Cause bits 15:8 show the live interrupt lines `irq[7:0]`. Bit 8 is the keyboard input and bit 9 is the display output. Cause bits 31:16, bit 7 and bits 1:0 read 0.
- R6: An interrupt is taken when Status bit 1 is 0, `irq` is nonzero and no supported exception or return request is present. It redirects to the vector, sets Status bit 1, writes code 0 into Cause bits 6:2 and loads EPC with `ev_pc`. While Status bit 1 is 1, interrupt lines cause no redirect.
- R7: A supported exception presented in the same cycle as an interrupt wins. Cause records the exception's code.
- R8: A return request with no supported exception redirects in the same cycle to the current EPC value and clears Status bit 1 at the next edge. A supported exception in the same cycle takes precedence.
- R9: A move-to write to register 12 or 14 stores the full 32-bit value, and a move-from read of that number returns it.
- R10: Move-to writes to registers 8, 13 and any unimplemented number are ignored. Move-from reads of unimplemented numbers return 0.
- R11: A move-to write in the same cycle as any redirecting event is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Exception code of the request |
| ev_pc | input | 32 | PC of the faulting or currently executing instruction |
| ev_addr | input | 32 | Offending address for address faults |
| irq | input | 8 | Level interrupt request lines |
| eret_req | input | 1 | Return-from-exception request |
| mt_en | input | 1 | Move-to write enable |
| mt_sel | input | 5 | Move-to register number |
| mt_data | input | 32 | Move-to write data |
| mf_sel | input | 5 | Move-from register number |
| mf_data | output | 32 | Move-from read data |
| redirect | output | 1 | PC redirect strobe |
| redirect_pc | output | 32 | Redirect target |

## Verification
A wrong exception-level flag is visible at the next cycle in two ways. Interrupts get through when they should be blocked, or they are refused when they should be taken. Both show directly on `redirect`. A wrong code decode shows as a missing or spurious redirect in the same cycle. It also shows as a wrong Cause, EPC or BadVAddr value on the first read after the edge. A stale EPC appears as a wrong `redirect_pc` on the very next return request.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter logic [31:0] VECTOR = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_req,
  input  logic [4:0]  exc_code,
  input  logic [31:0] ev_pc,
  input  logic [31:0] ev_addr,
  input  logic [7:0]  irq,
  input  logic        eret_req,
  input  logic        mt_en,
  input  logic [4:0]  mt_sel,
  input  logic [31:0] mt_data,
  input  logic [4:0]  mf_sel,
  output logic [31:0] mf_data,
  output logic        redirect,
  output logic [31:0] redirect_pc
);
  localparam logic [4:0] N_BAD = 5'd8;
  localparam logic [4:0] N_STAT = 5'd12;
  localparam logic [4:0] N_CAUSE = 5'd13;
  localparam logic [4:0] N_EPC = 5'd14;

  logic [31:0] status_q, epc_q, bad_q;
  logic [4:0]  code_q;
  logic        code_ok, addr_fault, exc_take, eret_take, irq_take, event_any;

  always_comb begin
    case (exc_code)
      5'd4, 5'd5, 5'd8, 5'd9, 5'd10, 5'd12, 5'd13: code_ok = 1'b1;
      default: code_ok = 1'b0;
    endcase
  end

  assign addr_fault = (exc_code == 5'd4) || (exc_code == 5'd5);
  assign exc_take   = exc_req && code_ok;
  assign eret_take  = eret_req && !exc_take;
  assign irq_take   = !exc_take && !eret_req && !status_q[1] && (irq != 8'd0);
  assign event_any  = exc_take || eret_take || irq_take;

  assign redirect    = event_any;
  assign redirect_pc = eret_take ? epc_q : VECTOR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      epc_q    <= '0;
      bad_q    <= '0;
      code_q   <= '0;
    end else if (exc_take || irq_take) begin
      status_q[1] <= 1'b1;
      code_q      <= exc_take ? exc_code : 5'd0;
      epc_q       <= ev_pc;
      if (exc_take && addr_fault) bad_q <= ev_addr;
    end else if (eret_take) begin
      status_q[1] <= 1'b0;
    end else if (mt_en) begin
      if (mt_sel == N_STAT) status_q <= mt_data;
      if (mt_sel == N_EPC)  epc_q    <= mt_data;
    end
  end

  always_comb begin
    case (mf_sel)
      N_BAD:   mf_data = bad_q;
      N_STAT:  mf_data = status_q;
      N_CAUSE: mf_data = {16'd0, irq, 1'b0, code_q, 2'b00};
      N_EPC:   mf_data = epc_q;
      default: mf_data = 32'd0;
    endcase
  end

  a_r2_epc_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && code_ok) |=> (epc_q == $past(ev_pc)) && status_q[1] && (code_q == $past(exc_code)));

  a_r3_bad_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req && code_ok && addr_fault) |=> $stable(bad_q));

  a_r4_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !code_ok && !redirect && !mt_en) |=> $stable(status_q) && $stable(epc_q) && $stable(code_q));

  a_r6_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[1] && !exc_req && !eret_req) |-> !redirect);

  a_r6_irq_record: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take) |=> status_q[1] && (code_q == 5'd0));

  a_r8_eret_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_req && !(exc_req && code_ok)) |=> !status_q[1]);

  a_r11_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && mt_en && mt_sel == N_EPC && !(exc_req && code_ok) && !irq_take) |=> $stable(epc_q));
endmodule

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  logic clk = 0, rst_n = 0;
  logic exc_req = 0, eret_req = 0, mt_en = 0;
  logic [4:0] exc_code = 0, mt_sel = 0, mf_sel = 0;
  logic [31:0] ev_pc = 0, ev_addr = 0, mt_data = 0;
  logic [7:0] irq = 0;
  logic [31:0] mf_data, redirect_pc;
  logic redirect;
  int checks = 0, failures = 0;
  logic [31:0] m_stat, m_epc, m_bad, rd;
  logic [4:0] m_code;
  localparam logic [31:0] VEC = 32'h8000_0180;

  exc_ctrl dut (.*);

  always #5 clk = ~clk;

  initial begin
    #1_000_000;
    failures++; checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    exc_req = 0; eret_req = 0; mt_en = 0; irq = 0;
  endtask

  task automatic rdreg(input logic [4:0] n, output logic [31:0] v);
    mf_sel = n; #1; v = mf_data;
  endtask

  task automatic regs(input string tag);
    rdreg(5'd12, rd); chk({tag, " status"}, rd, m_stat);
    rdreg(5'd13, rd); chk({tag, " cause"}, rd, {16'd0, irq, 1'b0, m_code, 2'b00});
    rdreg(5'd14, rd); chk({tag, " epc"}, rd, m_epc);
    rdreg(5'd8, rd);  chk({tag, " badvaddr"}, rd, m_bad);
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    mt_en = 1; mt_sel = n; mt_data = d; step();
    if (n == 5'd12) m_stat = d;
    if (n == 5'd14) m_epc = d;
  endtask

  function automatic bit sup(input logic [4:0] c);
    return c == 4 || c == 5 || c == 8 || c == 9 || c == 10 || c == 12 || c == 13;
  endfunction

  initial begin
    m_stat = 0; m_epc = 0; m_bad = 0; m_code = 0;
    repeat (2) @(posedge clk); #1; rst_n = 1; #1;
    regs("R1 reset");
    chk("R1 redirect idle", {31'd0, redirect}, 0);

    for (int c = 0; c < 32; c++) begin
      wr(5'd12, 32'd0);
      exc_req = 1; exc_code = c[4:0]; ev_pc = 32'h0040_0000 + c * 4; ev_addr = 32'hA000_0000 + c;
      #1;
      chk(sup(c[4:0]) ? "R2 redirect" : "R4 no redirect", {31'd0, redirect}, {31'd0, sup(c[4:0])});
      if (sup(c[4:0])) chk("R2 vector", redirect_pc, VEC);
      step();
      if (sup(c[4:0])) begin
        m_stat[1] = 1; m_code = c[4:0]; m_epc = 32'h0040_0000 + c * 4;
        if (c == 4 || c == 5) m_bad = 32'hA000_0000 + c;
      end
      regs(sup(c[4:0]) ? "R2 R3 after exception" : "R4 ignored");
    end

    for (int p = 1; p < 256; p++) begin
      wr(5'd12, 32'd0);
      irq = p[7:0]; ev_pc = 32'h0050_0000 + p; #1;
      chk("R6 irq redirect", {31'd0, redirect}, 1);
      chk("R6 irq vector", redirect_pc, VEC);
      rdreg(5'd13, rd); chk("R5 pending", rd, {16'd0, p[7:0], 1'b0, m_code, 2'b00});
      step();
      m_stat[1] = 1; m_code = 0; m_epc = 32'h0050_0000 + p;
      regs("R6 after irq");
      irq = p[7:0]; #1;
      chk("R6 blocked when level set", {31'd0, redirect}, 0);
      step();
    end

    wr(5'd12, 32'd0);
    irq = 8'h03; exc_req = 1; exc_code = 5'd12; ev_pc = 32'h0060_0000; #1;
    chk("R7 redirect", {31'd0, redirect}, 1);
    step();
    m_stat[1] = 1; m_code = 12; m_epc = 32'h0060_0000;
    regs("R7 exception wins");

    wr(5'd14, 32'h0060_0004);
    eret_req = 1; #1;
    chk("R8 eret redirect", {31'd0, redirect}, 1);
    chk("R8 eret target", redirect_pc, 32'h0060_0004);
    step();
    m_stat[1] = 0;
    regs("R8 after eret");

    wr(5'd12, 32'h0000_0002);
    eret_req = 1; exc_req = 1; exc_code = 5'd9; ev_pc = 32'h0070_0000; #1;
    chk("R8 exception beats eret target", redirect_pc, VEC);
    step();
    m_stat[1] = 1; m_code = 9; m_epc = 32'h0070_0000;
    regs("R8 exception beats eret");

    for (int n = 0; n < 32; n++) begin
      wr(n[4:0], 32'hC0DE_0000 | n);
      rdreg(n[4:0], rd);
      if (n == 12 || n == 14) chk("R9 readback", rd, 32'hC0DE_0000 | n);
      else if (n == 8) chk("R10 badvaddr write ignored", rd, m_bad);
      else if (n == 13) chk("R10 cause write ignored", rd, {16'd0, 8'd0, 1'b0, m_code, 2'b00});
      else chk("R10 unimplemented reads zero", rd, 32'd0);
    end

    m_epc = 32'h0000_1000; wr(5'd14, m_epc);
    eret_req = 1; mt_en = 1; mt_sel = 5'd14; mt_data = 32'hDEAD_BEEF; step();
    m_stat[1] = 0;
    regs("R11 write dropped on eret");
    mt_en = 1; mt_sel = 5'd12; mt_data = 32'h0; exc_req = 1; exc_code = 5'd13; ev_pc = 32'h0080_0000;
    step();
    m_stat[1] = 1; m_code = 13; m_epc = 32'h0080_0000;
    regs("R11 write dropped on exception");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule